// File: doc/BRIEF.md
# Trap and Interrupt Priority Arbiter

This block decides, once per clock, whether the processor leaves its current flow for an exception, and which one it takes. Eight non-maskable trap lines, each fixed to one of the levels 8 to 15, compete with one maskable interrupt request. The interrupt request arrives already reduced to a single pending level from 1 to 7, with 0 meaning none. The block holds the CPU priority level itself. When it accepts a request, it pulses a strobe, reports a vector index and raises the level to that of the winner. The old level is kept on a small stack so that a return-from-exception input can restore it.

Traps sit above every interrupt level, so bit 3 of the priority level is set for as long as a trap is being serviced. A level of 7 blocks all interrupts but never a trap. Traps nest: a higher trap preempts a lower one that is being serviced. Requests are accepted only at an instruction boundary, so the faulting instruction completes first. Software may set the level through a 3-bit write. Fetching the vector, saving registers and enabling individual interrupts are done elsewhere.

Top module: `ipl_trap_arbiter`

## Requirements
- R1: After reset the CPU level is 0, the take strobe is 0 and the vector index is 0.
- R2: Trap line i requests level 8+i. When several trap lines are set, the highest i wins, and on acceptance the vector index is i and the level becomes 8+i.
- R3: An interrupt pending at level L (1 to 7) is accepted only when L is strictly greater than the current level. It then gives vector index L+8 and sets the level to L.
- R4: Any pending trap wins over a pending interrupt in the same cycle.
- R5: A request whose level is equal to or lower than the current level is not taken, and the level does not change.
- R6: At level 7 (binary 0111) an interrupt at level 7 or lower is refused, but any trap is still accepted.
- R7: During a trap a higher trap preempts the current one and pushes the current level. An equal or lower trap waits.
- R8: Requests are accepted only in a cycle in which `instr_done` is 1.
- R9: A cycle with `ret` set pops the saved level into the CPU level and takes no exception. With an empty stack, `ret` leaves the level unchanged.
- R10: `lvl_wr` loads {0, `lvl_wdata`} into the level only when bit 3 of the level is 0 and no return or acceptance happens in that cycle. While bit 3 of the level is 1, the write is ignored.
- R11: When the level stack holds STACK_DEPTH entries, no request is accepted until a return frees an entry.
- R12: `take` is a one-cycle pulse per acceptance. `take`, `vec_idx` and `cpu_level` all change at the clock edge that samples the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 8 | Trap request lines, bit i at level 8+i |
| irq_level | input | 3 | Pending interrupt level, 0 = none |
| instr_done | input | 1 | Instruction boundary: requests may be accepted |
| ret | input | 1 | Return from exception, restores the saved level |
| lvl_wr | input | 1 | Software write of the CPU level |
| lvl_wdata | input | 3 | Level value for the software write |
| take | output | 1 | Exception accepted, one-cycle pulse |
| vec_idx | output | 4 | Vector index of the accepted exception |
| cpu_level | output | 4 | Current CPU priority level |

## Verification
Every result of this block appears one clock edge after the inputs that cause it: `take`, `vec_idx` and `cpu_level` are all registers loaded at the edge that samples a request, a return or a write. The bench drives its inputs 1 ns after a rising edge and waits for the next rising edge. It then samples 1 ns later, so each check reads the value produced by exactly one edge. Requests are removed before the following edge, so a request that is held too long or pushed twice shows up as a wrong level on a later check.

// File: rtl/trap_arb_pkg.sv
package trap_arb_pkg;
  localparam int LVL_W    = 4;
  localparam int NUM_TRAP = 8;
  localparam int TIDX_W   = $clog2(NUM_TRAP);

  typedef logic [LVL_W-1:0] lvl_t;

  // trap line index -> priority level (8..15)
  function automatic lvl_t trap_level(input logic [TIDX_W-1:0] idx);
    return lvl_t'(NUM_TRAP) + lvl_t'(idx);
  endfunction

  // accepted level -> vector index
  function automatic lvl_t exc_vector(input logic is_trap, input lvl_t lvl);
    return is_trap ? lvl_t'(lvl - lvl_t'(NUM_TRAP)) : lvl_t'(lvl + lvl_t'(NUM_TRAP));
  endfunction
endpackage

// File: rtl/trap_prio_enc.sv
module trap_prio_enc #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          valid,
  output logic [IW-1:0] idx
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        valid = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lvl_stack.sv
module lvl_stack #(
  parameter int W     = 4,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] cnt;
  logic [AW-1:0] wr_a, rd_a;

  assign wr_a  = AW'(cnt);
  assign rd_a  = AW'(cnt - PW'(1));
  assign full  = (cnt == PW'(DEPTH));
  assign empty = (cnt == '0);
  assign top   = mem[rd_a];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push && !full) begin
      mem[wr_a] <= din;
      cnt       <= cnt + PW'(1);
    end else if (pop && !empty) begin
      cnt <= cnt - PW'(1);
    end
  end
endmodule

// File: rtl/ipl_trap_arbiter.sv
module ipl_trap_arbiter
  import trap_arb_pkg::*;
#(
  parameter int STACK_DEPTH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRAP-1:0] trap_req,
  input  logic [2:0]          irq_level,
  input  logic                instr_done,
  input  logic                ret,
  input  logic                lvl_wr,
  input  logic [2:0]          lvl_wdata,
  output logic                take,
  output logic [LVL_W-1:0]    vec_idx,
  output logic [LVL_W-1:0]    cpu_level
);
  // named internal events
  logic              trap_valid;
  logic [TIDX_W-1:0] trap_idx;
  logic              irq_valid;
  logic              cand_valid;
  logic              cand_trap;
  lvl_t              cand_lvl;
  logic              accept;
  logic              do_pop;
  logic              sw_wr;
  logic              stk_full, stk_empty;
  lvl_t              stk_top;

  trap_prio_enc #(.N(NUM_TRAP)) u_enc (
    .req   (trap_req),
    .valid (trap_valid),
    .idx   (trap_idx)
  );

  assign irq_valid  = (irq_level != 3'd0);
  assign cand_valid = trap_valid || irq_valid;
  assign cand_trap  = trap_valid;
  assign cand_lvl   = trap_valid ? trap_level(trap_idx) : {1'b0, irq_level};

  assign do_pop = ret && !stk_empty;
  assign accept = instr_done && !ret && cand_valid && !stk_full && (cand_lvl > cpu_level);
  assign sw_wr  = lvl_wr && !ret && !accept && !cpu_level[LVL_W-1];

  lvl_stack #(.W(LVL_W), .DEPTH(STACK_DEPTH)) u_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (accept),
    .pop   (do_pop),
    .din   (cpu_level),
    .top   (stk_top),
    .full  (stk_full),
    .empty (stk_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take      <= 1'b0;
      vec_idx   <= '0;
      cpu_level <= '0;
    end else begin
      take <= accept;
      if (do_pop) begin
        cpu_level <= stk_top;
      end else if (accept) begin
        cpu_level <= cand_lvl;
        vec_idx   <= exc_vector(cand_trap, cand_lvl);
      end else if (sw_wr) begin
        cpu_level <= {1'b0, lvl_wdata};
      end
    end
  end
endmodule

// File: rtl/ipl_trap_arbiter_chk.sv
module ipl_trap_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] trap_req,
  input logic       instr_done,
  input logic       ret,
  input logic       take,
  input logic [3:0] vec_idx,
  input logic [3:0] cpu_level,
  input logic       stk_full
);
  // R5: an acceptance always raises the level
  a_r5_take_raises_level: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (cpu_level > $past(cpu_level)));

  // R8: acceptance only at an instruction boundary
  a_r8_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(instr_done));

  // R4: a pending trap leads to a trap-level acceptance
  a_r4_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (take && $past(|trap_req)) |-> cpu_level[3]);

  // R2 / R3: the vector index agrees with the new level
  a_r2_vec_matches_level: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (vec_idx[2:0] == cpu_level[2:0] && vec_idx[3] == !cpu_level[3]));

  // R9: no acceptance in a return cycle
  a_r9_no_take_on_ret: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ret) |-> !take);

  // R11: a full stack blocks acceptance
  a_r11_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stk_full) |-> !take);

  // R10: bit 3 is only cleared by a return
  a_r10_trap_bit_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cpu_level[3]) && !$past(ret)) |-> cpu_level[3]);
endmodule

bind ipl_trap_arbiter ipl_trap_arbiter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trap_req   (trap_req),
  .instr_done (instr_done),
  .ret        (ret),
  .take       (take),
  .vec_idx    (vec_idx),
  .cpu_level  (cpu_level),
  .stk_full   (stk_full)
);

// File: tb/ipl_trap_arbiter_test.sv
`timescale 1ns/1ps
module ipl_trap_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] trap_req = '0;
  logic [2:0] irq_level = '0;
  logic       instr_done = 1'b0;
  logic       ret = 1'b0;
  logic       lvl_wr = 1'b0;
  logic [2:0] lvl_wdata = '0;
  logic       take;
  logic [3:0] vec_idx;
  logic [3:0] cpu_level;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ipl_trap_arbiter uut (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .irq_level(irq_level),
    .instr_done(instr_done), .ret(ret), .lvl_wr(lvl_wr), .lvl_wdata(lvl_wdata),
    .take(take), .vec_idx(vec_idx), .cpu_level(cpu_level)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    trap_req = '0; irq_level = '0; ret = 1'b0; lvl_wr = 1'b0; instr_done = 1'b1;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  // one cycle of stimulus, then check the results of that edge
  task automatic step_chk(input string req, input int e_take, input int e_vec, input int e_lvl);
    tick();
    check(req, "take", int'(take), e_take);
    if (e_take != 0) check(req, "vec_idx", int'(vec_idx), e_vec);
    check(req, "cpu_level", int'(cpu_level), e_lvl);
    idle();
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "cpu_level", int'(cpu_level), 0);
    check("R1", "take", int'(take), 0);
    check("R1", "vec_idx", int'(vec_idx), 0);
  endtask

  task automatic t_irq();
    irq_level = 3'd3; step_chk("R3", 1, 11, 3);
    step_chk("R12", 0, 0, 3);           // single pulse
    irq_level = 3'd2; step_chk("R5", 0, 0, 3);
    irq_level = 3'd3; step_chk("R5", 0, 0, 3);
  endtask

  task automatic t_trap_prio();
    trap_req = 8'b0010_0100; irq_level = 3'd7;
    step_chk("R2", 1, 5, 13);           // R4: trap beats irq 7
    trap_req = 8'b1000_0000; step_chk("R7", 1, 7, 15);
    trap_req = 8'b0000_1000; step_chk("R7", 0, 0, 15);
  endtask

  task automatic t_return();
    ret = 1'b1; trap_req = 8'hFF; step_chk("R9", 0, 0, 13);
    ret = 1'b1; step_chk("R9", 0, 0, 3);
    ret = 1'b1; step_chk("R9", 0, 0, 0);
    ret = 1'b1; step_chk("R9", 0, 0, 0);   // empty stack
  endtask

  task automatic t_mask7();
    lvl_wr = 1'b1; lvl_wdata = 3'd7; step_chk("R10", 0, 0, 7);
    irq_level = 3'd7; step_chk("R6", 0, 0, 7);
    trap_req = 8'b0000_0001; step_chk("R6", 1, 0, 8);
    lvl_wr = 1'b1; lvl_wdata = 3'd2; step_chk("R10", 0, 0, 8);
    ret = 1'b1; step_chk("R9", 0, 0, 7);
  endtask

  task automatic t_boundary();
    trap_req = 8'b0000_0010; instr_done = 1'b0;
    tick();
    check("R8", "take", int'(take), 0);
    check("R8", "cpu_level", int'(cpu_level), 7);
    instr_done = 1'b1; step_chk("R8", 1, 1, 9);
    ret = 1'b1; step_chk("R9", 0, 0, 7);
  endtask

  task automatic t_full();
    do_reset();
    for (int l = 1; l <= 7; l++) begin
      irq_level = 3'(l); step_chk("R11", 1, l + 8, l);
    end
    trap_req = 8'b0000_0001; step_chk("R11", 1, 0, 8);
    trap_req = 8'b1000_0000; step_chk("R11", 0, 0, 8);
    ret = 1'b1; step_chk("R11", 0, 0, 7);
    trap_req = 8'b1000_0000; step_chk("R11", 1, 7, 15);
  endtask

  initial begin
    t_reset();
    t_irq();
    t_trap_prio();
    t_return();
    t_mask7();
    t_boundary();
    t_full();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule